// File: doc/BRIEF.md
# Dual-flash command snoop striper

This block sits between a byte-wide transmit FIFO / receive FIFO pair and two serial byte buses that drive a pair of flash devices wired in parallel. At the start of every chip-select period it inspects the first byte sent, treats it as a flash opcode, and from that opcode works out how many address and dummy bytes follow. While those bytes go out, both devices must see identical traffic: one byte is popped per slot, every active bus is strobed with it in the same cycle, and only bus 0's response is written back. Once the countdown runs out, the block stripes: each bus takes its own byte from the transmit FIFO, buses are served in ascending order one per cycle, and each bus's response is pushed, so receive order follows transmit order.

Dual-bus operation applies only when both the separate-bus and the two-memory configuration inputs are high; otherwise bus 0 alone carries all traffic. A one-cycle `kick` starts a burst that drains the transmit FIFO. The burst ends when a pop is needed and the FIFO is empty, and that event raises a transmit-underflow pulse unless linear mode is selected. A response that meets a full receive FIFO is dropped and flagged. The serial shifters behind each bus are outside this block; each bus returns its response in the cycle it is strobed.

Top module: `snoop_striper`

## Requirements
- R1: Opcodes 0x03, 0x02, 0xA2 and 0x32 are followed by exactly 3 bytes sent identically on all active buses; striping starts with the fifth byte of the chip-select period.
- R2: Opcodes 0x0B, 0x3B, 0x6B and 0xBB are followed by exactly 4 identically sent bytes before striping starts.
- R3: Opcode 0xEB is followed by exactly 6 identically sent bytes before striping starts.
- R4: Any other first byte makes every later byte of that chip-select period go out identically on all active buses; striping never starts.
- R5: Outside striping, each slot pops one transmit byte, strobes every active bus in the same cycle with that byte, and pushes only bus 0's response (bus 0 response = the byte bus 0 returned).
- R6: While striping, each active bus pops its own byte; buses are served in ascending index order, one per cycle, and each bus's response is pushed in that order.
- R7: Both buses are active only when `cfg_sep_bus` and `cfg_two_mem` are both 1; otherwise only `bus_xfer[0]` ever pulses.
- R8: `cs_idle` high at a rising clock edge returns the snoop state to opcode checking; without it, striping persists across bursts.
- R9: When a pop is needed and `tx_empty` is 1, nothing is popped, the burst ends (`busy` low the next cycle), and `tx_underflow` pulses for that cycle unless `linear_mode` is 1.
- R10: When a byte is served while `rx_full` is 1, `rx_push` stays low and `rx_overflow` pulses in that cycle instead.
- R11: After reset `busy`, `tx_pop` and `bus_xfer` are 0; a `kick` while idle makes `busy` high from the next cycle, and transfers occur only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick | input | 1 | Start a burst that drains the transmit FIFO |
| cs_idle | input | 1 | No chip select is active; resets the snoop state |
| cfg_sep_bus | input | 1 | Separate-bus configuration bit |
| cfg_two_mem | input | 1 | Two-memory configuration bit |
| linear_mode | input | 1 | Suppresses the underflow flag |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_byte | input | DW | Transmit FIFO head byte |
| tx_pop | output | 1 | Pop the transmit FIFO |
| rx_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Push `rx_byte` into the receive FIFO |
| rx_byte | output | DW | Response byte to store |
| rx_overflow | output | 1 | Response dropped because the receive FIFO was full |
| tx_underflow | output | 1 | Pop needed while the transmit FIFO was empty |
| busy | output | 1 | Burst in progress |
| bus_xfer | output | NUM_BUS | Per-bus byte transfer strobe |
| bus_tx | output | NUM_BUS*DW | Per-bus byte to send (bus i at bits i*DW) |
| bus_rx | input | NUM_BUS*DW | Per-bus response, valid in the strobe cycle |

## Verification
Strobes, pops, pushes and the two flags are combinational on the registered burst and snoop state, so each is due in the same cycle the FIFO flags present the byte, while `busy` rises one cycle after `kick` and a snoop-state change first shows in the slot after the byte that caused it. The bench drives inputs just after a rising edge and records every strobe, push and flag at the falling edge, so each observation belongs to exactly one clock cycle. Expected per-bus byte sequences, response order and flag counts come from a bench model of the countdown rules, compared once the burst has ended.

// File: rtl/snoop_stripe_pkg.sv
package snoop_stripe_pkg;

   typedef enum logic [1:0] {
      SNP_CHECK  = 2'd0,
      SNP_COUNT  = 2'd1,
      SNP_NONE   = 2'd2,
      SNP_STRIPE = 2'd3
   } snp_mode_e;

   // Bytes that follow the opcode before striping begins.
   localparam int GAP_PLAIN   = 3;
   localparam int GAP_FAST    = 4;
   localparam int GAP_QUAD_IO = 6;

   localparam logic [7:0] OPC_READ      = 8'h03;
   localparam logic [7:0] OPC_PROG      = 8'h02;
   localparam logic [7:0] OPC_PROG_DUAL = 8'hA2;
   localparam logic [7:0] OPC_PROG_QUAD = 8'h32;
   localparam logic [7:0] OPC_FAST      = 8'h0B;
   localparam logic [7:0] OPC_FAST_DOUT = 8'h3B;
   localparam logic [7:0] OPC_FAST_QOUT = 8'h6B;
   localparam logic [7:0] OPC_FAST_DIO  = 8'hBB;
   localparam logic [7:0] OPC_FAST_QIO  = 8'hEB;

endpackage

// File: rtl/snoop_opdec.sv
module snoop_opdec
   import snoop_stripe_pkg::*;
#(
   parameter int DW    = 8,
   parameter int CNT_W = 3
) (
   input  logic [DW-1:0]    opcode,
   output logic             known,
   output logic [CNT_W-1:0] gap
);

   logic [7:0] op8;
   assign op8 = opcode[7:0];

   generate
      if (DW > 8) begin : g_wide
         logic upper_unused;
         assign upper_unused = ^opcode[DW-1:8];
      end
   endgenerate

   always_comb begin
      known = 1'b1;
      gap   = '0;
      case (op8)
         OPC_READ, OPC_PROG, OPC_PROG_DUAL, OPC_PROG_QUAD:
            gap = CNT_W'(GAP_PLAIN);
         OPC_FAST, OPC_FAST_DOUT, OPC_FAST_QOUT, OPC_FAST_DIO:
            gap = CNT_W'(GAP_FAST);
         OPC_FAST_QIO:
            gap = CNT_W'(GAP_QUAD_IO);
         default: begin
            known = 1'b0;
            gap   = '0;
         end
      endcase
   end

endmodule

// File: rtl/snoop_tracker.sv
module snoop_tracker
   import snoop_stripe_pkg::*;
#(
   parameter int DW    = 8,
   parameter int CNT_W = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_idle,
   input  logic          slot_done,
   input  logic [DW-1:0] slot_byte,
   output logic          striping
);

   snp_mode_e        mode_q;
   logic [CNT_W-1:0] left_q;
   logic             op_known;
   logic [CNT_W-1:0] op_gap;

   snoop_opdec #(.DW(DW), .CNT_W(CNT_W)) i_opdec (
      .opcode (slot_byte),
      .known  (op_known),
      .gap    (op_gap)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= SNP_CHECK;
         left_q <= '0;
      end else if (cs_idle) begin
         mode_q <= SNP_CHECK;
         left_q <= '0;
      end else if (slot_done) begin
         case (mode_q)
            SNP_CHECK: begin
               if (!op_known) begin
                  mode_q <= SNP_NONE;
                  left_q <= '0;
               end else if (op_gap == '0) begin
                  mode_q <= SNP_STRIPE;
                  left_q <= '0;
               end else begin
                  mode_q <= SNP_COUNT;
                  left_q <= op_gap;
               end
            end
            SNP_COUNT: begin
               if (left_q <= CNT_W'(1)) begin
                  mode_q <= SNP_STRIPE;
                  left_q <= '0;
               end else begin
                  left_q <= left_q - 1'b1;
               end
            end
            default: begin
               mode_q <= mode_q;
               left_q <= left_q;
            end
         endcase
      end
   end

   assign striping = (mode_q == SNP_STRIPE);

endmodule

// File: rtl/snoop_lane_seq.sv
module snoop_lane_seq #(
   parameter int NUM_BUS = 2,
   parameter int LANE_W  = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               kick,
   input  logic               tx_empty,
   input  logic               striping,
   input  logic               multi,
   input  logic               linear_mode,
   output logic               busy,
   output logic               tx_pop,
   output logic               slot_done,
   output logic               tx_underflow,
   output logic [NUM_BUS-1:0] serve_mask,
   output logic [LANE_W-1:0]  serve_lane
);

   logic              busy_q;
   logic              stall;
   logic              lane_end;
   logic              split;
   logic [LANE_W-1:0] lane_q;
   logic [LANE_W-1:0] last_lane;
   logic [LANE_W-1:0] act_lane;

   assign split        = striping & multi;
   assign last_lane    = multi ? LANE_W'(NUM_BUS - 1) : '0;
   assign stall        = busy_q & tx_empty;
   assign tx_pop       = busy_q & ~tx_empty;
   assign tx_underflow = stall & ~linear_mode;
   assign act_lane     = split ? lane_q : '0;
   assign lane_end     = (act_lane >= last_lane);
   assign slot_done    = tx_pop & (~striping | lane_end);
   assign serve_lane   = act_lane;
   assign busy         = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
      end else if (!busy_q) begin
         busy_q <= kick;
      end else if (stall) begin
         busy_q <= 1'b0;
      end
   end

   generate
      if (NUM_BUS == 1) begin : g_one_lane
         assign lane_q = '0;
      end else begin : g_lanes
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lane_q <= '0;
            end else if (!busy_q || stall || !split) begin
               lane_q <= '0;
            end else if (tx_pop) begin
               lane_q <= lane_end ? '0 : lane_q + 1'b1;
            end
         end
      end

      for (genvar gi = 0; gi < NUM_BUS; gi++) begin : g_mask
         if (gi == 0) begin : g_first
            assign serve_mask[gi] = tx_pop & (~striping | (act_lane == '0));
         end else begin : g_other
            assign serve_mask[gi] = tx_pop & multi &
                                    (~striping | (act_lane == LANE_W'(gi)));
         end
      end
   endgenerate

endmodule

// File: rtl/snoop_bus_port.sv
module snoop_bus_port #(
   parameter int DW      = 8,
   parameter int NUM_BUS = 2,
   parameter int LANE_W  = 1
) (
   input  logic [NUM_BUS-1:0]    serve_mask,
   input  logic                  tx_pop,
   input  logic [LANE_W-1:0]     serve_lane,
   input  logic [DW-1:0]         tx_byte,
   input  logic [NUM_BUS*DW-1:0] bus_rx,
   input  logic                  rx_full,
   output logic [NUM_BUS-1:0]    bus_xfer,
   output logic [NUM_BUS*DW-1:0] bus_tx,
   output logic [DW-1:0]         rx_byte,
   output logic                  rx_push,
   output logic                  rx_overflow
);

   generate
      for (genvar gi = 0; gi < NUM_BUS; gi++) begin : g_bus
         assign bus_xfer[gi]         = serve_mask[gi];
         assign bus_tx[gi*DW +: DW]  = serve_mask[gi] ? tx_byte : '0;
      end
   endgenerate

   always_comb begin
      rx_byte = '0;
      for (int i = 0; i < NUM_BUS; i++) begin
         if (serve_lane == LANE_W'(i)) begin
            rx_byte = bus_rx[i*DW +: DW];
         end
      end
   end

   assign rx_push     = tx_pop & ~rx_full;
   assign rx_overflow = tx_pop & rx_full;

endmodule

// File: rtl/snoop_striper.sv
module snoop_striper #(
   parameter int DW      = 8,
   parameter int NUM_BUS = 2,
   parameter int CNT_W   = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  kick,
   input  logic                  cs_idle,
   input  logic                  cfg_sep_bus,
   input  logic                  cfg_two_mem,
   input  logic                  linear_mode,
   input  logic                  tx_empty,
   input  logic [DW-1:0]         tx_byte,
   output logic                  tx_pop,
   input  logic                  rx_full,
   output logic                  rx_push,
   output logic [DW-1:0]         rx_byte,
   output logic                  rx_overflow,
   output logic                  tx_underflow,
   output logic                  busy,
   output logic [NUM_BUS-1:0]    bus_xfer,
   output logic [NUM_BUS*DW-1:0] bus_tx,
   input  logic [NUM_BUS*DW-1:0] bus_rx
);

   localparam int LANE_W = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1;

   generate
      if (DW < 8) begin : g_bad_dw
         $error("snoop_striper: DW must be at least 8");
      end
      if (NUM_BUS < 1) begin : g_bad_bus
         $error("snoop_striper: NUM_BUS must be at least 1");
      end
      if (CNT_W < 3) begin : g_bad_cnt
         $error("snoop_striper: CNT_W must hold a gap of 6");
      end
   endgenerate

   logic               multi;
   logic               striping;
   logic               slot_done;
   logic [NUM_BUS-1:0] serve_mask;
   logic [LANE_W-1:0]  serve_lane;

   assign multi = cfg_sep_bus & cfg_two_mem;

   snoop_tracker #(.DW(DW), .CNT_W(CNT_W)) i_tracker (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_idle   (cs_idle),
      .slot_done (slot_done),
      .slot_byte (tx_byte),
      .striping  (striping)
   );

   snoop_lane_seq #(.NUM_BUS(NUM_BUS), .LANE_W(LANE_W)) i_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .kick         (kick),
      .tx_empty     (tx_empty),
      .striping     (striping),
      .multi        (multi),
      .linear_mode  (linear_mode),
      .busy         (busy),
      .tx_pop       (tx_pop),
      .slot_done    (slot_done),
      .tx_underflow (tx_underflow),
      .serve_mask   (serve_mask),
      .serve_lane   (serve_lane)
   );

   snoop_bus_port #(.DW(DW), .NUM_BUS(NUM_BUS), .LANE_W(LANE_W)) i_port (
      .serve_mask  (serve_mask),
      .tx_pop      (tx_pop),
      .serve_lane  (serve_lane),
      .tx_byte     (tx_byte),
      .bus_rx      (bus_rx),
      .rx_full     (rx_full),
      .bus_xfer    (bus_xfer),
      .bus_tx      (bus_tx),
      .rx_byte     (rx_byte),
      .rx_push     (rx_push),
      .rx_overflow (rx_overflow)
   );

endmodule

// File: rtl/snoop_striper_chk.sv
module snoop_striper_chk #(
   parameter int NUM_BUS = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               kick,
   input logic               cfg_sep_bus,
   input logic               cfg_two_mem,
   input logic               linear_mode,
   input logic               tx_empty,
   input logic               tx_pop,
   input logic               rx_full,
   input logic               rx_push,
   input logic               rx_overflow,
   input logic               tx_underflow,
   input logic               busy,
   input logic [NUM_BUS-1:0] bus_xfer
);

   AST_POP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |-> busy); // R11
   AST_KICK_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && kick) |=> busy); // R11
   AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |-> !tx_empty); // R9
   AST_UNDERFLOW_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_underflow |=> !busy); // R9
   AST_UNDERFLOW_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      tx_underflow |-> !linear_mode); // R9
   AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> !rx_full); // R10
   AST_RX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_push, rx_overflow})); // R10
   AST_SINGLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_sep_bus && cfg_two_mem) |-> ((bus_xfer >> 1) == '0)); // R7
   AST_BUS0_POPS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_xfer[0] |-> tx_pop); // R5
   AST_XFER_NEEDS_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_xfer != '0) |-> tx_pop); // R6

endmodule

bind snoop_striper snoop_striper_chk #(.NUM_BUS(NUM_BUS)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .kick         (kick),
   .cfg_sep_bus  (cfg_sep_bus),
   .cfg_two_mem  (cfg_two_mem),
   .linear_mode  (linear_mode),
   .tx_empty     (tx_empty),
   .tx_pop       (tx_pop),
   .rx_full      (rx_full),
   .rx_push      (rx_push),
   .rx_overflow  (rx_overflow),
   .tx_underflow (tx_underflow),
   .busy         (busy),
   .bus_xfer     (bus_xfer)
);

// File: tb/test_snoop_striper.sv
`timescale 1ns/1ps
module test_snoop_striper;

   localparam int DW = 8;
   localparam int NB = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          kick = 1'b0;
   logic          cs_idle = 1'b0;
   logic          cfg_sep_bus = 1'b0;
   logic          cfg_two_mem = 1'b0;
   logic          linear_mode = 1'b0;
   logic          tx_empty;
   logic [DW-1:0] tx_byte;
   logic          tx_pop;
   logic          rx_full = 1'b0;
   logic          rx_push;
   logic [DW-1:0] rx_byte;
   logic          rx_overflow;
   logic          tx_underflow;
   logic          busy;
   logic [NB-1:0] bus_xfer;
   logic [NB*DW-1:0] bus_tx;
   logic [NB*DW-1:0] bus_rx;

   always #5 clk = ~clk;

   snoop_striper #(.DW(DW), .NUM_BUS(NB)) i_snoop_striper (
      .clk (clk), .rst_n (rst_n), .kick (kick), .cs_idle (cs_idle),
      .cfg_sep_bus (cfg_sep_bus), .cfg_two_mem (cfg_two_mem),
      .linear_mode (linear_mode), .tx_empty (tx_empty), .tx_byte (tx_byte),
      .tx_pop (tx_pop), .rx_full (rx_full), .rx_push (rx_push),
      .rx_byte (rx_byte), .rx_overflow (rx_overflow),
      .tx_underflow (tx_underflow), .busy (busy), .bus_xfer (bus_xfer),
      .bus_tx (bus_tx), .bus_rx (bus_rx)
   );

   // Transmit FIFO model
   logic [7:0] tx_mem [0:63];
   logic [5:0] tx_wr = '0;
   logic [5:0] tx_rd;
   assign tx_empty = (tx_wr == tx_rd);
   assign tx_byte  = tx_mem[tx_rd];
   always @(posedge clk) begin
      if (!rst_n) tx_rd <= '0;
      else if (tx_pop) tx_rd <= tx_rd + 6'd1;
   end

   // Flash responders: bus 0 returns byte^5A, bus 1 returns byte^5B
   assign bus_rx = {bus_tx[15:8] ^ 8'h5B, bus_tx[7:0] ^ 8'h5A};

   // Observation log, sampled at the falling edge
   logic       clr_log = 1'b0;
   int         n_b0, n_b1, n_rx, n_uf, n_ov;
   logic [7:0] log_b0 [0:31];
   logic [7:0] log_b1 [0:31];
   logic [7:0] log_rx [0:31];
   always @(negedge clk) begin
      if (clr_log) begin
         n_b0 = 0; n_b1 = 0; n_rx = 0; n_uf = 0; n_ov = 0;
      end else if (rst_n) begin
         if (bus_xfer[0] && n_b0 < 32) begin log_b0[n_b0] = bus_tx[7:0]; n_b0++; end
         if (bus_xfer[1] && n_b1 < 32) begin log_b1[n_b1] = bus_tx[15:8]; n_b1++; end
         if (rx_push && n_rx < 32) begin log_rx[n_rx] = rx_byte; n_rx++; end
         if (tx_underflow) n_uf++;
         if (rx_overflow) n_ov++;
      end
   end

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // Expected sequences
   logic [7:0] stim [0:31];
   int         n_stim;
   logic [7:0] exp_b0 [0:31];
   logic [7:0] exp_b1 [0:31];
   logic [7:0] exp_rx [0:31];
   int         e0, e1, er;

   task automatic build_exp(input int pre, input bit multi);
      e0 = 0; e1 = 0; er = 0;
      for (int k = 0; k < n_stim; k++) begin
         if (k < pre) begin
            exp_b0[e0] = stim[k]; e0++;
            if (multi) begin exp_b1[e1] = stim[k]; e1++; end
            exp_rx[er] = stim[k] ^ 8'h5A; er++;
         end else if (multi && ((k - pre) % 2 == 1)) begin
            exp_b1[e1] = stim[k]; e1++;
            exp_rx[er] = stim[k] ^ 8'h5B; er++;
         end else begin
            exp_b0[e0] = stim[k]; e0++;
            exp_rx[er] = stim[k] ^ 8'h5A; er++;
         end
      end
   endtask

   task automatic run_burst(input logic [7:0] op, input int n_after,
                            input bit sep, input bit two, input bit lin,
                            input bit do_cs, input int pre);
      int w;
      @(posedge clk); #1;
      cfg_sep_bus = sep; cfg_two_mem = two; linear_mode = lin;
      if (do_cs) begin
         cs_idle = 1'b1; @(posedge clk); #1; cs_idle = 1'b0;
      end
      n_stim = n_after + 1;
      for (int k = 0; k < n_stim; k++) begin
         stim[k] = (k == 0) ? op : (8'h20 + 8'(k * 7));
         tx_mem[tx_wr] = stim[k];
         tx_wr = tx_wr + 6'd1;
      end
      build_exp(pre, sep & two);
      clr_log = 1'b1; @(posedge clk); #1; clr_log = 1'b0;
      kick = 1'b1; @(posedge clk); #1; kick = 1'b0;
      w = 0;
      while (busy && w < 200) begin @(posedge clk); #1; w++; end
      chk(w < 200, "R11", "burst ended", w, 0);
   endtask

   task automatic std_checks(input string tag, input int uf_exp);
      int mm;
      chk(n_b0 == e0, tag, "bus0 byte count", n_b0, e0);
      chk(n_b1 == e1, "R7", "bus1 byte count", n_b1, e1);
      mm = 0;
      for (int k = 0; k < e0 && k < n_b0; k++) if (log_b0[k] !== exp_b0[k]) mm++;
      chk(mm == 0, tag, "bus0 byte mismatches", mm, 0);
      mm = 0;
      for (int k = 0; k < e1 && k < n_b1; k++) if (log_b1[k] !== exp_b1[k]) mm++;
      chk(mm == 0, "R5", "bus1 byte mismatches", mm, 0);
      mm = (n_rx == er) ? 0 : 100;
      for (int k = 0; k < er && k < n_rx; k++) if (log_rx[k] !== exp_rx[k]) mm++;
      chk(mm == 0, "R6", "rx order mismatches", mm, 0);
      chk(n_uf == uf_exp, "R9", "underflow pulses", n_uf, uf_exp);
   endtask

   function automatic string tag_of(input logic [3:0] cnt);
      case (cnt)
         4'd3:    return "R1";
         4'd4:    return "R2";
         4'd6:    return "R3";
         default: return "R4";
      endcase
   endfunction

   // {opcode[13:6], sep[5], two[4], gap[3:0]}; gap 15 = no striping
   localparam int NV = 13;
   localparam logic [13:0] VEC [0:NV-1] = '{
      {8'h03, 1'b1, 1'b1, 4'd3},   // R1
      {8'h02, 1'b1, 1'b1, 4'd3},   // R1
      {8'hA2, 1'b1, 1'b1, 4'd3},   // R1
      {8'h32, 1'b1, 1'b1, 4'd3},   // R1
      {8'h0B, 1'b1, 1'b1, 4'd4},   // R2
      {8'h3B, 1'b1, 1'b1, 4'd4},   // R2
      {8'h6B, 1'b1, 1'b1, 4'd4},   // R2
      {8'hBB, 1'b1, 1'b1, 4'd4},   // R2
      {8'hEB, 1'b1, 1'b1, 4'd6},   // R3
      {8'h9F, 1'b1, 1'b1, 4'd15},  // R4
      {8'h03, 1'b1, 1'b0, 4'd3},   // R7 single bus
      {8'h03, 1'b0, 1'b1, 4'd3},   // R7 single bus
      {8'h0B, 1'b0, 1'b0, 4'd4}    // R7 single bus
   };

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(busy == 1'b0, "R11", "busy after reset", busy, 0);
      chk(tx_pop == 1'b0, "R11", "tx_pop after reset", tx_pop, 0);
      chk(bus_xfer == '0, "R11", "bus_xfer after reset", bus_xfer, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      for (int v = 0; v < NV; v++) begin
         logic [3:0] g;
         int pre;
         g = VEC[v][3:0];
         pre = (g == 4'd15) ? 11 : int'(g) + 1;
         run_burst(VEC[v][13:6], 10, VEC[v][5], VEC[v][4], 1'b0, 1'b1, pre);
         std_checks(tag_of(g), 1);
      end

      // R8: striping persists across bursts until cs_idle
      run_burst(8'h03, 4, 1'b1, 1'b1, 1'b0, 1'b1, 4);
      std_checks("R1", 1);
      run_burst(8'h11, 3, 1'b1, 1'b1, 1'b0, 1'b0, 0);
      std_checks("R8", 1);
      run_burst(8'h0B, 3, 1'b1, 1'b1, 1'b0, 1'b1, 5);
      std_checks("R8", 1);

      // R9: linear mode hides underflow
      run_burst(8'h03, 6, 1'b1, 1'b1, 1'b1, 1'b1, 4);
      std_checks("R9", 0);

      // R10: full receive FIFO drops responses
      @(posedge clk); #1; rx_full = 1'b1;
      run_burst(8'h9F, 2, 1'b0, 1'b0, 1'b0, 1'b1, 3);
      chk(n_rx == 0, "R10", "pushes while full", n_rx, 0);
      chk(n_ov == 3, "R10", "overflow pulses", n_ov, 3);
      chk(n_b0 == 3, "R10", "bytes still sent", n_b0, 3);
      rx_full = 1'b0;

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL R11 watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule